// File: doc/BRIEF.md
# System Address Map Target Decoder

This block turns a request's physical address and transaction kind into the node ID of the home node that must service it. A set of static configuration inputs describes the system: a 2-bit routing code for each address region, the node IDs of up to eight coherent home nodes, two I/O home nodes and one miscellaneous node, a coherent-node count mode, and the base of the 16MB configuration-register window. Each valid request produces one registered result one cycle later.

The address space is split into a non-uniform ladder of regions. The bottom 4GB uses eight equal 512MB slices. Above that, each region is twice the size of the one below it, up to the 8TB–16TB region at the top of the 44-bit space. Barrier and DVM operations ignore the address and go to the miscellaneous node. An access that hits the configuration window is routed to an I/O home node and flagged, so that the I/O node forwards it to the miscellaneous node. Ordinary coherent traffic is spread over the active coherent home nodes using an XOR fold of the address above the cache-line offset.

Top module: `sam_target_decoder`

## Requirements
- R1: `rspValid` equals `reqValid` one clock earlier. The result fields are captured only in cycles where `reqValid` is high, and they hold their value otherwise.
- R2: While `rstN` is low, `rspValid`, `rspNode`, `rspCsrHit` and `rspDecErr` are 0 and `rspClass` is 3 (none).
- R3: For an address below 4GB, the region number is `reqAddr[31:29]`. Otherwise the region number is 8 + (p − 32), where p is the highest set address bit. So bit 32 selects region 8 and bit 43 selects region 19.
- R4: The routing code of region r sits at `cfgRegionMap[2r+1:2r]`. Code 00 routes to the coherent group (class 0) and code 01 routes to an I/O home node (class 1).
- R5: A memory request outside the configuration window whose region code is 10 or 11 gives `rspDecErr`=1, `rspNode`=0 and `rspClass`=3.
- R6: The I/O home node is `cfgIoNode[5:0]` when `reqAddr[28]` is 0 and `cfgIoNode[11:6]` when it is 1.
- R7: A memory request with `reqAddr[43:24]` equal to `cfgCsrBase` gives `rspCsrHit`=1, class 1 and no error. It is routed by R6 whatever the region code.
- R8: `reqKind` 01 (barrier) and 10 (DVM) route to `cfgMiscNode` with class 2 and both flags 0, for any address. Kinds 00 and 11 are memory requests.
- R9: The coherent index bit j is the XOR of every `reqAddr[i]` with 6 ≤ i ≤ 43 and (i − 6) mod 3 = j.
- R10: `cfgCohMode` 0, 1 and 2 keep 0, 1 and 2 low bits of the index (1, 2 or 4 nodes). Values 3 to 7 keep all 3 bits (8 nodes). Index k selects `cfgCohNode[6k+5:6k]`, and the slots are filled in ascending node-ID order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present this cycle |
| reqKind | input | 2 | Transaction kind (00/11 memory, 01 barrier, 10 DVM) |
| reqAddr | input | 44 | Physical address |
| cfgRegionMap | input | 40 | Routing code per region, 2 bits each |
| cfgMiscNode | input | 6 | Miscellaneous node ID |
| cfgIoNode | input | 12 | Two I/O home node IDs |
| cfgCohNode | input | 48 | Eight coherent home node IDs, ascending |
| cfgCohMode | input | 3 | Coherent node count mode |
| cfgCsrBase | input | 20 | Configuration window base, address bits 43:24 |
| rspValid | output | 1 | Result valid |
| rspNode | output | 6 | Target node ID |
| rspClass | output | 2 | 0 coherent, 1 I/O, 2 miscellaneous, 3 none |
| rspCsrHit | output | 1 | Access hits the configuration window |
| rspDecErr | output | 1 | Reserved region code was hit |

## Verification
The hardest results to reach from the ports sit at the top of the region ladder and inside the configuration window. The top regions need addresses with several high bits set, so the stimulus combines bit 42 with bit 32 to show that the highest set bit picks the region while the lower bit still feeds the hash. The window override and the node-count modes depend on configuration that is only meant to change under reset. The bench therefore pulses reset, moves the window base into a coherent region or changes the mode, and then sends the same address again to see the routing change.

// File: rtl/sam_dec_pkg.sv
package sam_dec_pkg;

  typedef enum logic [1:0] {
    CLS_COH  = 2'd0,
    CLS_IO   = 2'd1,
    CLS_MISC = 2'd2,
    CLS_NONE = 2'd3
  } tgtClass_e;

  typedef enum logic [1:0] {
    KIND_MEM     = 2'd0,
    KIND_BARRIER = 2'd1,
    KIND_DVM     = 2'd2,
    KIND_MEM_ALT = 2'd3
  } reqKind_e;

  typedef enum logic [1:0] {
    MAP_COH      = 2'd0,
    MAP_IO       = 2'd1,
    MAP_RSVD     = 2'd2,
    MAP_RSVD_ALT = 2'd3
  } regionCode_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic load;       // capture a new result
    logic routeMisc;  // kind-based route to the miscellaneous node
  } ctrlStrobe_t;

  // Region count of the ladder: fine slices plus one region per upper bit.
  function automatic int regionCount(int addrW, int fineBits, int fineRegions);
    return fineRegions + addrW - fineBits - $clog2(fineRegions);
  endfunction

endpackage

// File: rtl/sam_dec_region.sv
module sam_dec_region #(
  parameter int ADDR_W       = 44,
  parameter int FINE_BITS    = 29,
  parameter int FINE_REGIONS = 8,
  parameter int IDX_W        = 5
) (
  input  logic [ADDR_W-1:FINE_BITS] addrHi,
  output logic [IDX_W-1:0]          regionIdx
);

  localparam int FINE_SEL_W  = $clog2(FINE_REGIONS);
  localparam int COARSE_BASE = FINE_BITS + FINE_SEL_W;

  // Fine slice by default; the highest set upper bit overrides it.
  always_comb begin
    regionIdx = IDX_W'(addrHi[FINE_BITS +: FINE_SEL_W]);
    for (int b = COARSE_BASE; b < ADDR_W; b++) begin
      if (addrHi[b]) regionIdx = IDX_W'(FINE_REGIONS + b - COARSE_BASE);
    end
  end

endmodule

// File: rtl/sam_dec_coh_sel.sv
module sam_dec_coh_sel #(
  parameter int ADDR_W    = 44,
  parameter int LINE_BITS = 6,
  parameter int COH_NODES = 8,
  parameter int MODE_W    = 3,
  localparam int COH_IDX_W = $clog2(COH_NODES)
) (
  input  logic [ADDR_W-1:LINE_BITS] addrHi,
  input  logic [MODE_W-1:0]         cohMode,
  output logic [COH_IDX_W-1:0]      cohIdx
);

  logic [COH_IDX_W-1:0] foldIdx;
  logic [COH_IDX_W-1:0] modeMask;

  // XOR fold of every bit above the line offset into the index width.
  always_comb begin
    foldIdx = '0;
    for (int i = LINE_BITS; i < ADDR_W; i++) begin
      foldIdx[(i - LINE_BITS) % COH_IDX_W] = foldIdx[(i - LINE_BITS) % COH_IDX_W] ^ addrHi[i];
    end
  end

  // Mode m keeps the m low index bits, saturating at the full width.
  always_comb begin
    for (int j = 0; j < COH_IDX_W; j++) begin
      modeMask[j] = (int'(cohMode) > j);
    end
  end

  assign cohIdx = foldIdx & modeMask;

endmodule

// File: rtl/sam_dec_ctrl.sv
module sam_dec_ctrl
  import sam_dec_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic [1:0]  reqKind,
  output ctrlStrobe_t strobe,
  output logic        rspValid
);

  logic kindIsMisc;

  assign kindIsMisc       = (reqKind == KIND_BARRIER) || (reqKind == KIND_DVM);
  assign strobe.load      = reqValid;
  assign strobe.routeMisc = reqValid && kindIsMisc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

endmodule

// File: rtl/sam_dec_datapath.sv
module sam_dec_datapath
  import sam_dec_pkg::*;
#(
  parameter int ADDR_W       = 44,
  parameter int FINE_BITS    = 29,
  parameter int FINE_REGIONS = 8,
  parameter int NODE_W       = 6,
  parameter int IO_NODES     = 2,
  parameter int COH_NODES    = 8,
  parameter int MODE_W       = 3,
  parameter int LINE_BITS    = 6,
  parameter int IO_SEL_BIT   = 28,
  parameter int CSR_BITS     = 24,
  localparam int NUM_REGIONS = regionCount(ADDR_W, FINE_BITS, FINE_REGIONS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  ctrlStrobe_t                 strobe,
  input  logic [ADDR_W-1:LINE_BITS]   addrHi,
  input  logic [2*NUM_REGIONS-1:0]    regionMap,
  input  logic [NODE_W-1:0]           miscNode,
  input  logic [IO_NODES*NODE_W-1:0]  ioNodes,
  input  logic [COH_NODES*NODE_W-1:0] cohNodes,
  input  logic [MODE_W-1:0]           cohMode,
  input  logic [ADDR_W-CSR_BITS-1:0]  csrBase,
  output logic [NODE_W-1:0]           node,
  output logic [1:0]                  tgtClass,
  output logic                        csrHit,
  output logic                        decErr
);

  localparam int REGION_IDX_W = $clog2(NUM_REGIONS);
  localparam int COH_IDX_W    = $clog2(COH_NODES);
  localparam int IO_IDX_W     = (IO_NODES > 1) ? $clog2(IO_NODES) : 1;

  logic [REGION_IDX_W-1:0] regionIdx;
  logic [COH_IDX_W-1:0]    cohIdx;
  logic [IO_IDX_W-1:0]     ioIdx;
  logic [1:0]              codeTable [NUM_REGIONS];
  logic [NODE_W-1:0]       cohTable  [COH_NODES];
  logic [NODE_W-1:0]       ioTable   [IO_NODES];
  logic [1:0]              regionCode;
  logic                    csrMatch;

  logic [NODE_W-1:0] nodeNext;
  tgtClass_e         classNext;
  logic              csrNext;
  logic              errNext;
  tgtClass_e         classQ;

  // Unpack the flat configuration buses.
  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_code
    assign codeTable[r] = regionMap[2*r +: 2];
  end
  for (genvar k = 0; k < COH_NODES; k++) begin : g_coh
    assign cohTable[k] = cohNodes[k*NODE_W +: NODE_W];
  end
  for (genvar k = 0; k < IO_NODES; k++) begin : g_io
    assign ioTable[k] = ioNodes[k*NODE_W +: NODE_W];
  end

  sam_dec_region #(
    .ADDR_W       (ADDR_W),
    .FINE_BITS    (FINE_BITS),
    .FINE_REGIONS (FINE_REGIONS),
    .IDX_W        (REGION_IDX_W)
  ) i_region (
    .addrHi    (addrHi[ADDR_W-1:FINE_BITS]),
    .regionIdx (regionIdx)
  );

  sam_dec_coh_sel #(
    .ADDR_W    (ADDR_W),
    .LINE_BITS (LINE_BITS),
    .COH_NODES (COH_NODES),
    .MODE_W    (MODE_W)
  ) i_coh_sel (
    .addrHi  (addrHi),
    .cohMode (cohMode),
    .cohIdx  (cohIdx)
  );

  assign regionCode = codeTable[regionIdx];
  assign csrMatch   = (addrHi[ADDR_W-1:CSR_BITS] == csrBase);
  assign ioIdx      = addrHi[IO_SEL_BIT +: IO_IDX_W];

  // Priority: transaction kind, then configuration window, then region code.
  always_comb begin
    nodeNext  = '0;
    classNext = CLS_NONE;
    csrNext   = 1'b0;
    errNext   = 1'b0;
    if (strobe.routeMisc) begin
      nodeNext  = miscNode;
      classNext = CLS_MISC;
    end else if (csrMatch) begin
      nodeNext  = ioTable[ioIdx];
      classNext = CLS_IO;
      csrNext   = 1'b1;
    end else begin
      unique case (regionCode)
        MAP_COH: begin
          nodeNext  = cohTable[cohIdx];
          classNext = CLS_COH;
        end
        MAP_IO: begin
          nodeNext  = ioTable[ioIdx];
          classNext = CLS_IO;
        end
        default: begin
          errNext = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      node   <= '0;
      classQ <= CLS_NONE;
      csrHit <= 1'b0;
      decErr <= 1'b0;
    end else if (strobe.load) begin
      node   <= nodeNext;
      classQ <= classNext;
      csrHit <= csrNext;
      decErr <= errNext;
    end
  end

  assign tgtClass = classQ;

endmodule

// File: rtl/sam_target_decoder.sv
module sam_target_decoder
  import sam_dec_pkg::*;
#(
  parameter int ADDR_W       = 44,
  parameter int FINE_BITS    = 29,
  parameter int FINE_REGIONS = 8,
  parameter int NODE_W       = 6,
  parameter int IO_NODES     = 2,
  parameter int COH_NODES    = 8,
  parameter int MODE_W       = 3,
  parameter int LINE_BITS    = 6,
  parameter int IO_SEL_BIT   = 28,
  parameter int CSR_BITS     = 24
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  input  logic [1:0]                  reqKind,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [2*regionCount(ADDR_W, FINE_BITS, FINE_REGIONS)-1:0] cfgRegionMap,
  input  logic [NODE_W-1:0]           cfgMiscNode,
  input  logic [IO_NODES*NODE_W-1:0]  cfgIoNode,
  input  logic [COH_NODES*NODE_W-1:0] cfgCohNode,
  input  logic [MODE_W-1:0]           cfgCohMode,
  input  logic [ADDR_W-CSR_BITS-1:0]  cfgCsrBase,
  output logic                        rspValid,
  output logic [NODE_W-1:0]           rspNode,
  output logic [1:0]                  rspClass,
  output logic                        rspCsrHit,
  output logic                        rspDecErr
);

  ctrlStrobe_t strobe;
  logic        unusedLineOffset;

  // The line offset never influences routing.
  assign unusedLineOffset = ^reqAddr[LINE_BITS-1:0];

  sam_dec_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqKind  (reqKind),
    .strobe   (strobe),
    .rspValid (rspValid)
  );

  sam_dec_datapath #(
    .ADDR_W       (ADDR_W),
    .FINE_BITS    (FINE_BITS),
    .FINE_REGIONS (FINE_REGIONS),
    .NODE_W       (NODE_W),
    .IO_NODES     (IO_NODES),
    .COH_NODES    (COH_NODES),
    .MODE_W       (MODE_W),
    .LINE_BITS    (LINE_BITS),
    .IO_SEL_BIT   (IO_SEL_BIT),
    .CSR_BITS     (CSR_BITS)
  ) i_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .addrHi    (reqAddr[ADDR_W-1:LINE_BITS]),
    .regionMap (cfgRegionMap),
    .miscNode  (cfgMiscNode),
    .ioNodes   (cfgIoNode),
    .cohNodes  (cfgCohNode),
    .cohMode   (cfgCohMode),
    .csrBase   (cfgCsrBase),
    .node      (rspNode),
    .tgtClass  (rspClass),
    .csrHit    (rspCsrHit),
    .decErr    (rspDecErr)
  );

endmodule

// File: rtl/sam_dec_checker.sv
module sam_dec_checker
  import sam_dec_pkg::*;
#(
  parameter int ADDR_W       = 44,
  parameter int FINE_BITS    = 29,
  parameter int FINE_REGIONS = 8,
  parameter int NODE_W       = 6,
  parameter int IO_NODES     = 2,
  parameter int COH_NODES    = 8,
  parameter int MODE_W       = 3,
  parameter int CSR_BITS     = 24
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        reqValid,
  input logic [1:0]                  reqKind,
  input logic [ADDR_W-1:0]           reqAddr,
  input logic [2*regionCount(ADDR_W, FINE_BITS, FINE_REGIONS)-1:0] cfgRegionMap,
  input logic [NODE_W-1:0]           cfgMiscNode,
  input logic [IO_NODES*NODE_W-1:0]  cfgIoNode,
  input logic [COH_NODES*NODE_W-1:0] cfgCohNode,
  input logic [MODE_W-1:0]           cfgCohMode,
  input logic [ADDR_W-CSR_BITS-1:0]  cfgCsrBase,
  input logic                        rspValid,
  input logic [NODE_W-1:0]           rspNode,
  input logic [1:0]                  rspClass,
  input logic                        rspCsrHit,
  input logic                        rspDecErr
);

  logic unusedCfg;
  assign unusedCfg = ^{cfgRegionMap, cfgIoNode, cfgCohNode, cfgCohMode};

  logic kindMisc;
  logic kindMem;
  assign kindMisc = (reqKind == KIND_BARRIER) || (reqKind == KIND_DVM);
  assign kindMem  = !kindMisc;

  // R1
  p_valid_rise_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  // R1
  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
  // R1
  p_hold_result_r1: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(rspNode) && $stable(rspClass)
                   && $stable(rspCsrHit) && $stable(rspDecErr)));
  // R8
  p_misc_route_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && kindMisc) |=> (rspClass == CLS_MISC && rspNode == $past(cfgMiscNode)
                                && !rspCsrHit && !rspDecErr));
  // R5
  p_err_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    rspDecErr |-> (rspNode == '0 && rspClass == CLS_NONE && !rspCsrHit));
  // R7
  p_csr_is_io_r7: assert property (@(posedge clk) disable iff (!rstN)
    rspCsrHit |-> (rspClass == CLS_IO && !rspDecErr));
  // R7
  p_csr_detect_r7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && kindMem && reqAddr[ADDR_W-1:CSR_BITS] == cfgCsrBase) |=> rspCsrHit);

endmodule

bind sam_target_decoder sam_dec_checker #(
  .ADDR_W       (ADDR_W),
  .FINE_BITS    (FINE_BITS),
  .FINE_REGIONS (FINE_REGIONS),
  .NODE_W       (NODE_W),
  .IO_NODES     (IO_NODES),
  .COH_NODES    (COH_NODES),
  .MODE_W       (MODE_W),
  .CSR_BITS     (CSR_BITS)
) i_checker (.*);

// File: tb/test_sam_target_decoder.sv
module test_sam_target_decoder;

  typedef struct packed {
    logic [43:0] addr;
    logic [1:0]  kind;
    logic [5:0]  node;
    logic [1:0]  cls;
    logic        csr;
    logic        err;
  } vec_t;

  // Config: mode 3, window base 0x3F, coherent IDs 10..17, I/O 40/41, misc 50.
  localparam int NVEC = 18;
  localparam vec_t VECS [NVEC] = '{
    '{44'h000_0000_0000, 2'd0, 6'd10, 2'd0, 1'b0, 1'b0},  // R9 zero fold
    '{44'h000_0000_0040, 2'd0, 6'd11, 2'd0, 1'b0, 1'b0},  // R9 bit 6
    '{44'h000_0000_01C0, 2'd0, 6'd17, 2'd0, 1'b0, 1'b0},  // R9 bits 6..8
    '{44'h000_0000_0240, 2'd0, 6'd10, 2'd0, 1'b0, 1'b0},  // R9 bits 6,9 cancel
    '{44'h000_0000_0080, 2'd3, 6'd12, 2'd0, 1'b0, 1'b0},  // R8 kind 11 is memory
    '{44'h000_A000_0000, 2'd0, 6'd16, 2'd0, 1'b0, 1'b0},  // R3 region 5
    '{44'h000_2000_0000, 2'd0, 6'd40, 2'd1, 1'b0, 1'b0},  // R6 bit28=0
    '{44'h000_3000_0000, 2'd0, 6'd41, 2'd1, 1'b0, 1'b0},  // R6 bit28=1
    '{44'h000_3F00_1000, 2'd0, 6'd41, 2'd1, 1'b1, 1'b0},  // R7 window hit
    '{44'h000_4000_0000, 2'd0, 6'd0,  2'd3, 1'b0, 1'b1},  // R5 code 10
    '{44'h000_6000_0000, 2'd0, 6'd0,  2'd3, 1'b0, 1'b1},  // R5 code 11
    '{44'h001_0000_0000, 2'd0, 6'd40, 2'd1, 1'b0, 1'b0},  // R3 region 8
    '{44'h002_0000_0000, 2'd0, 6'd11, 2'd0, 1'b0, 1'b0},  // R3 region 9
    '{44'h800_0000_0000, 2'd0, 6'd40, 2'd1, 1'b0, 1'b0},  // R3 region 19
    '{44'h800_1000_0000, 2'd0, 6'd41, 2'd1, 1'b0, 1'b0},  // R4 region 19 I/O
    '{44'h401_0000_0000, 2'd0, 6'd15, 2'd0, 1'b0, 1'b0},  // R3 highest bit wins
    '{44'h000_4000_0000, 2'd1, 6'd50, 2'd2, 1'b0, 1'b0},  // R8 barrier
    '{44'h000_3F00_0000, 2'd2, 6'd50, 2'd2, 1'b0, 1'b0}   // R8 DVM in window
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        reqValid;
  logic [1:0]  reqKind;
  logic [43:0] reqAddr;
  logic [39:0] cfgRegionMap;
  logic [5:0]  cfgMiscNode;
  logic [11:0] cfgIoNode;
  logic [47:0] cfgCohNode;
  logic [2:0]  cfgCohMode;
  logic [19:0] cfgCsrBase;
  logic        rspValid;
  logic [5:0]  rspNode;
  logic [1:0]  rspClass;
  logic        rspCsrHit;
  logic        rspDecErr;

  int checkCount = 0;
  int failCount  = 0;

  always #10 clk = ~clk;

  sam_target_decoder i_sam_target_decoder (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqKind      (reqKind),
    .reqAddr      (reqAddr),
    .cfgRegionMap (cfgRegionMap),
    .cfgMiscNode  (cfgMiscNode),
    .cfgIoNode    (cfgIoNode),
    .cfgCohNode   (cfgCohNode),
    .cfgCohMode   (cfgCohMode),
    .cfgCsrBase   (cfgCsrBase),
    .rspValid     (rspValid),
    .rspNode      (rspNode),
    .rspClass     (rspClass),
    .rspCsrHit    (rspCsrHit),
    .rspDecErr    (rspDecErr)
  );

  task automatic checkOut(input string tag, input logic v, input logic [5:0] n,
                          input logic [1:0] c, input logic h, input logic e);
    checkCount++;
    if ({rspValid, rspNode, rspClass, rspCsrHit, rspDecErr} !== {v, n, c, h, e}) begin
      failCount++;
      $display("FAIL %s: actual valid=%0b node=%0d class=%0d csr=%0b err=%0b, expected valid=%0b node=%0d class=%0d csr=%0b err=%0b",
               tag, rspValid, rspNode, rspClass, rspCsrHit, rspDecErr, v, n, c, h, e);
    end
  endtask

  task automatic sendReq(input logic [43:0] a, input logic [1:0] k);
    reqValid = 1'b1;
    reqAddr  = a;
    reqKind  = k;
    @(negedge clk);
  endtask

  task automatic resetWith(input logic [2:0] mode, input logic [19:0] base);
    rstN       = 1'b0;
    reqValid   = 1'b0;
    cfgCohMode = mode;
    cfgCsrBase = base;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    rstN       = 1'b0;
    reqValid   = 1'b0;
    reqKind    = 2'd0;
    reqAddr    = '0;
    cfgMiscNode = 6'd50;
    cfgIoNode  = {6'd41, 6'd40};
    for (int k = 0; k < 8; k++) cfgCohNode[6*k +: 6] = 6'(10 + k);
    cfgRegionMap = '0;
    cfgRegionMap[3:2]   = 2'b01;  // region 1 I/O
    cfgRegionMap[5:4]   = 2'b10;  // region 2 reserved
    cfgRegionMap[7:6]   = 2'b11;  // region 3 reserved
    cfgRegionMap[17:16] = 2'b01;  // region 8 I/O
    cfgRegionMap[39:38] = 2'b01;  // region 19 I/O
    cfgCohMode = 3'd3;
    cfgCsrBase = 20'h0003F;

    repeat (3) @(negedge clk);
    checkOut("R2 reset state", 1'b0, 6'd0, 2'd3, 1'b0, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      sendReq(VECS[i].addr, VECS[i].kind);
      checkOut($sformatf("R3/R4/R9 vector %0d", i), 1'b1, VECS[i].node,
               VECS[i].cls, VECS[i].csr, VECS[i].err);
    end

    // R1: idle cycle keeps the last result, valid drops.
    reqValid = 1'b0;
    reqAddr  = 44'h40;
    reqKind  = 2'd0;
    @(negedge clk);
    checkOut("R1 hold while idle", 1'b0, 6'd50, 2'd2, 1'b0, 1'b0);
    sendReq(44'h40, 2'd0);
    checkOut("R1 resume", 1'b1, 6'd11, 2'd0, 1'b0, 1'b0);

    // R10: count modes, same address with fold index 7.
    resetWith(3'd0, 20'h0003F);
    checkOut("R2 reset after traffic", 1'b0, 6'd0, 2'd3, 1'b0, 1'b0);
    sendReq(44'h1C0, 2'd0);
    checkOut("R10 mode 0", 1'b1, 6'd10, 2'd0, 1'b0, 1'b0);
    resetWith(3'd1, 20'h0003F);
    sendReq(44'h1C0, 2'd0);
    checkOut("R10 mode 1", 1'b1, 6'd11, 2'd0, 1'b0, 1'b0);
    resetWith(3'd2, 20'h0003F);
    sendReq(44'h1C0, 2'd0);
    checkOut("R10 mode 2", 1'b1, 6'd13, 2'd0, 1'b0, 1'b0);
    resetWith(3'd5, 20'h0003F);
    sendReq(44'h1C0, 2'd0);
    checkOut("R10 mode 5 saturates", 1'b1, 6'd17, 2'd0, 1'b0, 1'b0);

    // R7: window placed in a coherent region still routes to I/O.
    resetWith(3'd3, 20'h00001);
    sendReq(44'h000_0100_0040, 2'd0);
    checkOut("R7 window overrides coherent code", 1'b1, 6'd40, 2'd1, 1'b1, 1'b0);
    sendReq(44'h000_0200_0040, 2'd0);
    checkOut("R7 outside window coherent", 1'b1, 6'd13, 2'd0, 1'b0, 1'b0);

    reqValid = 1'b0;
    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    failCount++;
    $display("FAIL R1 watchdog: actual running, expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule